// File: doc/BRIEF.md
# Synchronous Clock Source Selector

This block picks one reference clock from a set of candidate sources. Each candidate supplies five things:

- an enable flag set by configuration,
- an availability flag from its own signal monitor,
- a numeric preference,
- a quality code taken from received synchronisation status messages,
- a configured replacement for that quality code.

On every clock cycle the block ranks all candidates that are both enabled and available. It registers the winner's index, a valid flag, and a one-cycle pulse that marks a switch between references.

The ranking has three keys, taken in this order:

1. The effective quality code. A smaller code is better.
2. The preference number. A smaller number is better.
3. The source index. The lower index wins.

The effective quality code is the configured replacement when the replacement is enabled, or when no message quality is being received. Otherwise it is the received code. The all-ones code means "quality unknown", and it ranks below every known quality.

When no candidate qualifies, the block drops valid and keeps the last index, so downstream timing logic can enter holdover.

Top module: `clk_src_sel`

## Requirements
- R1: A source whose `src_nominated` bit is 0 is never reported as the selection.
- R2: A source whose `src_available` bit is 0 is never reported as the selection.
- R3: Among qualifying sources, the one with the numerically smallest effective quality code wins, whatever the preference values. The all-ones code (4'hF with default widths) loses to every other code.
- R4: Among qualifying sources with equal effective quality, the smallest `src_prio` value wins, and 0 is the most preferred.
- R5: When effective quality and preference are both equal, the lowest source index wins.
- R6: When a source's `src_ovr_en` bit is 1, its `src_ovr_ql` field replaces its `src_rx_ql` field in the ranking.
- R7: When a source's `src_rx_ql_ok` bit is 0, its `src_ovr_ql` field is used in the ranking whatever `src_ovr_en` is.
- R8: When no source qualifies, `sel_valid` is 0 and `sel_idx` keeps its previous value.
- R9: `sel_change` is 1 for exactly one cycle when a newly registered `sel_idx` differs from the previous one. It is 0 otherwise, including when valid drops or when valid returns on the same index.
- R10: The outputs reflect the inputs sampled at the preceding rising clock edge. While `rst_n` is low, `sel_idx` is 0, and `sel_valid` and `sel_change` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_nominated | input | NUM_SRC | Per-source enable for selection |
| src_available | input | NUM_SRC | Per-source qualified signal present |
| src_prio | input | NUM_SRC*PRIO_W | Preference per source, source i at bits [i*PRIO_W +: PRIO_W] |
| src_rx_ql | input | NUM_SRC*QL_W | Received quality code per source, same packing |
| src_rx_ql_ok | input | NUM_SRC | Received quality code is present |
| src_ovr_en | input | NUM_SRC | Replacement quality code enabled |
| src_ovr_ql | input | NUM_SRC*QL_W | Replacement quality code per source |
| sel_idx | output | IDX_W | Selected source index |
| sel_valid | output | 1 | A source is selected |
| sel_change | output | 1 | One-cycle pulse on index switch |

## Verification
All three outputs come from one register stage. A change of inputs applied before a rising edge is therefore visible on `sel_idx`, `sel_valid` and `sel_change` right after that edge, and `sel_change` falls again one edge later. The bench changes inputs on falling edges and advances its model by one step per cycle, using the inputs it has just applied. It compares all three outputs on the next falling edge, so every expectation lines up with exactly one register delay. Directed steps isolate each ranking key, the two replacement rules, the holdover case and the pulse behaviour. A long random run then checks the ranking against the model on every cycle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   localparam int unsigned CLKSEL_MIN_SRC   = 2;
   localparam int unsigned CLKSEL_MAX_SRC   = 64;
   localparam int unsigned CLKSEL_MIN_FIELD = 1;
endpackage

// File: rtl/clksel_ql_mux.sv
module clksel_ql_mux #(
   parameter int unsigned QL_W = 4
) (
   input  logic [QL_W-1:0] rx_ql,
   input  logic            rx_ok,
   input  logic            ovr_en,
   input  logic [QL_W-1:0] ovr_ql,
   output logic [QL_W-1:0] eff_ql
);
   logic use_ovr;

   assign use_ovr = ovr_en | ~rx_ok;

   always_comb begin
      if (use_ovr) eff_ql = ovr_ql;
      else         eff_ql = rx_ql;
   end
endmodule

// File: rtl/clksel_rank.sv
module clksel_rank #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned KEY_W   = 8,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [NUM_SRC-1:0]       elig,
   input  logic [NUM_SRC*KEY_W-1:0] keys,
   output logic [IDX_W-1:0]         win_idx,
   output logic                     win_any
);
   logic [KEY_W-1:0] best_key [NUM_SRC+1];
   logic [IDX_W-1:0] best_idx [NUM_SRC+1];
   logic             best_any [NUM_SRC+1];

   assign best_key[0] = '0;
   assign best_idx[0] = '0;
   assign best_any[0] = 1'b0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
      logic [KEY_W-1:0] cand_key;
      logic             take;
      assign cand_key = keys[i*KEY_W +: KEY_W];
      // strict compare: an earlier (lower) index keeps a tie
      assign take = elig[i] && (!best_any[i] || (cand_key < best_key[i]));
      assign best_key[i+1] = take ? cand_key        : best_key[i];
      assign best_idx[i+1] = take ? IDX_W'(i)       : best_idx[i];
      assign best_any[i+1] = take | best_any[i];
   end

   assign win_idx = best_idx[NUM_SRC];
   assign win_any = best_any[NUM_SRC];

   always_comb begin
      if (win_any) begin
         assert_win_qualifies_R2 : assert (elig[win_idx])
            else $error("rank winner is not a qualifying source");
      end
   end
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned QL_W    = 4,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_nominated,
   input  logic [NUM_SRC-1:0]        src_available,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic [NUM_SRC*QL_W-1:0]   src_rx_ql,
   input  logic [NUM_SRC-1:0]        src_rx_ql_ok,
   input  logic [NUM_SRC-1:0]        src_ovr_en,
   input  logic [NUM_SRC*QL_W-1:0]   src_ovr_ql,
   output logic [IDX_W-1:0]          sel_idx,
   output logic                      sel_valid,
   output logic                      sel_change
);
   import clksel_pkg::*;

   localparam int unsigned KEY_W = QL_W + PRIO_W;

   if (NUM_SRC < CLKSEL_MIN_SRC || NUM_SRC > CLKSEL_MAX_SRC) begin : g_bad_num
      $error("NUM_SRC out of supported range");
   end
   if (PRIO_W < CLKSEL_MIN_FIELD || QL_W < CLKSEL_MIN_FIELD) begin : g_bad_width
      $error("field widths must be at least one bit");
   end

   logic [NUM_SRC-1:0]       elig;
   logic [NUM_SRC*KEY_W-1:0] keys;
   logic [IDX_W-1:0]         win_idx;
   logic                     win_any;
   logic [IDX_W-1:0]         idx_q;
   logic                     valid_q;
   logic                     chg_q;

   assign elig = src_nominated & src_available;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [QL_W-1:0] eff_ql;
      clksel_ql_mux #(.QL_W(QL_W)) ql_mux_i (
         .rx_ql  (src_rx_ql[i*QL_W +: QL_W]),
         .rx_ok  (src_rx_ql_ok[i]),
         .ovr_en (src_ovr_en[i]),
         .ovr_ql (src_ovr_ql[i*QL_W +: QL_W]),
         .eff_ql (eff_ql)
      );
      // quality in the upper bits so it dominates preference
      assign keys[i*KEY_W +: KEY_W] = {eff_ql, src_prio[i*PRIO_W +: PRIO_W]};
   end

   clksel_rank #(.NUM_SRC(NUM_SRC), .KEY_W(KEY_W), .IDX_W(IDX_W)) rank_i (
      .elig    (elig),
      .keys    (keys),
      .win_idx (win_idx),
      .win_any (win_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         valid_q <= 1'b0;
         chg_q   <= 1'b0;
      end else begin
         valid_q <= win_any;
         if (win_any) begin
            idx_q <= win_idx;
            chg_q <= (win_idx != idx_q);
         end else begin
            chg_q <= 1'b0;
         end
      end
   end

   assign sel_idx    = idx_q;
   assign sel_valid  = valid_q;
   assign sel_change = chg_q;

   assert_sel_qualified_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ((($past(elig) >> sel_idx) & NUM_SRC'(1)) != '0))
      else $error("selected source was not qualifying");

   assert_none_invalid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(|elig) |-> !sel_valid)
      else $error("valid with no qualifying source");

   assert_hold_index_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> $stable(sel_idx))
      else $error("index moved while invalid");

   assert_change_moves_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_change |-> (sel_valid && sel_idx != $past(sel_idx)))
      else $error("change pulse without index switch");

   assert_change_single_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      sel_change |=> !sel_change || sel_idx != $past(sel_idx))
      else $error("change pulse stretched");
endmodule

// File: tb/clk_src_sel_tb_top.sv
`timescale 1ns/1ps
module clk_src_sel_tb_top;
   localparam int N  = 4;
   localparam int PW = 4;
   localparam int QW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    nom = '0, avl = '0, rxok = '0, oen = '0;
   logic [N*PW-1:0] prio = '0;
   logic [N*QW-1:0] rxql = '0, oql = '0;
   logic [1:0] sel_idx;
   logic       sel_valid, sel_change;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int m_idx = 0;
   bit m_valid = 0;
   bit m_chg = 0;

   always #4 clk = ~clk;

   clk_src_sel #(.NUM_SRC(N), .PRIO_W(PW), .QL_W(QW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_nominated(nom), .src_available(avl), .src_prio(prio),
      .src_rx_ql(rxql), .src_rx_ql_ok(rxok), .src_ovr_en(oen), .src_ovr_ql(oql),
      .sel_idx(sel_idx), .sel_valid(sel_valid), .sel_change(sel_change)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_src(int i, bit n, bit a, int p, bit ok, int rq, bit oe, int oq);
      nom[i] = n; avl[i] = a; rxok[i] = ok; oen[i] = oe;
      prio[i*PW +: PW] = PW'(p);
      rxql[i*QW +: QW] = QW'(rq);
      oql[i*QW +: QW]  = QW'(oq);
   endtask

   function automatic int eff_ql(int i);
      if (oen[i] || !rxok[i]) return int'(oql[i*QW +: QW]);
      return int'(rxql[i*QW +: QW]);
   endfunction

   // Model: narrow by quality, then by preference, then take lowest index
   task automatic model_step();
      int bq = 1000, bp = 1000, win = -1;
      for (int i = 0; i < N; i++)
         if (nom[i] && avl[i] && eff_ql(i) < bq) bq = eff_ql(i);
      for (int i = 0; i < N; i++)
         if (nom[i] && avl[i] && eff_ql(i) == bq && int'(prio[i*PW +: PW]) < bp)
            bp = int'(prio[i*PW +: PW]);
      for (int i = N - 1; i >= 0; i--)
         if (nom[i] && avl[i] && eff_ql(i) == bq && int'(prio[i*PW +: PW]) == bp) win = i;
      if (win >= 0) begin
         m_chg = (win != m_idx);
         m_idx = win;
         m_valid = 1;
      end else begin
         m_valid = 0;
         m_chg = 0;
      end
   endtask

   task automatic cycle(string tag);
      model_step();
      @(negedge clk);
      chk(tag, int'(sel_idx), m_idx);
      chk("R8", int'(sel_valid), int'(m_valid));
      chk("R9", int'(sel_change), int'(m_chg));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset idx", int'(sel_idx), 0);
      chk("R10 reset valid", int'(sel_valid), 0);
      chk("R10 reset change", int'(sel_change), 0);
      rst_n = 1'b1;
      cycle("R8 idle");
      set_src(2, 1, 1, 5, 1, 3, 0, 0);
      cycle("R1 single source");
      set_src(1, 1, 0, 9, 1, 0, 0, 0);
      cycle("R2 unavailable ignored");
      set_src(3, 0, 1, 0, 1, 0, 0, 0);
      cycle("R1 not nominated ignored");
      avl[1] = 1'b1;
      cycle("R3 better quality wins");
      rxql[1*QW +: QW] = 4'd3;
      cycle("R4 lower preference wins");
      prio[1*PW +: PW] = 4'd5;
      cycle("R5 lower index wins tie");
      oen[1] = 1'b1; oql[1*QW +: QW] = 4'd8;
      cycle("R6 replacement applied");
      oen[1] = 1'b0; rxok[1] = 1'b0; oql[1*QW +: QW] = 4'd1;
      cycle("R7 replacement when no rx");
      oql[1*QW +: QW] = 4'hF; prio[1*PW +: PW] = 4'd0;
      rxql[2*QW +: QW] = 4'hE; prio[2*PW +: PW] = 4'hF;
      cycle("R3 unknown quality ranks last");
      nom = '0;
      cycle("R8 holdover");
      cycle("R9 no pulse while held");
      nom[2] = 1'b1;
      cycle("R9 same index returns");
      set_src(0, 1, 1, 0, 1, 2, 0, 0);
      cycle("R9 switch pulse");
      cycle("R9 pulse ends");
      for (int k = 0; k < 400; k++) begin
         for (int i = 0; i < N; i++)
            set_src(i, ($urandom % 4) != 0, ($urandom % 4) != 0, int'($urandom % 4),
                    ($urandom % 3) != 0, int'($urandom % 5) + ((($urandom % 6) == 0) ? 11 : 0),
                    ($urandom % 4) == 0, int'($urandom % 16));
         cycle("R10 random");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule